// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This unit decides whether an event raised by a guest must leave the guest through a virtual-machine exit. The caller presents one event per check: a 12-bit type code, a 64-bit parameter and, for model-specific-register accesses, the register index. Static configuration inputs supply a global enable, a 64-bit general intercept vector, four 16-bit bitmaps for control- and debug-register reads and writes, a 32-bit exception bitmap and the base address of an in-memory register permission map.

Most event types are settled from the configuration vectors alone, one cycle after acceptance. A register access whose general bit is set needs one byte of the permission map. The unit fetches that byte through a single-byte read port with a request/valid handshake and any latency. Three disjoint index windows are packed into one bit space at two bits per register, one for read and one for write. An index outside all three windows exits at once, with no fetch. Every check ends with one `done` pulse. When the event is intercepted, `exit_req` rises in the same cycle, with the type on `exit_code` and the parameter on `exit_info`.

Top module: `vm_intercept_unit`

## Requirements
- R1: While `icpt_en` is low at acceptance, the check completes with `exit_req` low, whatever the type, and no map fetch is made.
- R2: Types 0x000–0x008 test bit (type−0x000) of `crr_map`. Types 0x010–0x018 test bit (type−0x010) of `crw_map`. A set bit means exit.
- R3: Types 0x020–0x027 test bit (type−0x020) of `drr_map`. Types 0x030–0x037 test bit (type−0x030) of `drw_map`.
- R4: Types 0x040–0x05F test bit (type−0x040) of `exc_map`.
- R5: Types 0x060–0x09F, except 0x07C, test bit (type−0x060) of `gen_vec`. Any type in no range never exits.
- R6: The register-access type 0x07C with `gen_vec[28]` clear completes without exit and without a map fetch.
- R7: For type 0x07C with `gen_vec[28]` set, the map bit offset is 2·idx for idx 0x0–0x1FFF, 2·(8192+idx−0xC0000000) for 0xC0000000–0xC0001FFF, and 2·(16384+idx−0xC0010000) for 0xC0010000–0xC0011FFF. The byte fetched is `map_base` + offset/8.
- R8: Parameter bit 0 clear tests bit (offset mod 8) of the fetched byte (read). Parameter bit 0 set tests the next bit (write). A set bit means exit.
- R9: Type 0x07C with `gen_vec[28]` set and an index outside all three windows exits one cycle after acceptance, with no fetch.
- R10: On an exit, `exit_code` equals the type and `exit_info` equals the full parameter.
- R11: Only one check is in flight at a time. A request presented while `busy` is high is ignored and produces no completion.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is seen. The request drops and `done` rises in the cycle after `mem_valid`.
- R13: Each accepted check yields exactly one `done` pulse. `exit_req` is only ever high together with `done`. Non-fetch checks complete one cycle after acceptance, so back-to-back requests are allowed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | Check request, accepted when `busy` is low |
| chk_type | input | 12 | Event type code |
| chk_param | input | 64 | Event parameter |
| msr_index | input | 32 | Register index for register-access events |
| icpt_en | input | 1 | Global intercept enable |
| gen_vec | input | 64 | General intercept vector |
| crr_map | input | 16 | Control-register read bitmap |
| crw_map | input | 16 | Control-register write bitmap |
| drr_map | input | 16 | Debug-register read bitmap |
| drw_map | input | 16 | Debug-register write bitmap |
| exc_map | input | 32 | Exception bitmap |
| map_base | input | 32 | Byte address of the permission map |
| mem_req | output | 1 | Map byte read request |
| mem_addr | output | 32 | Map byte address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 8 | Read data byte |
| busy | output | 1 | A map fetch is in flight |
| done | output | 1 | Check complete, one cycle |
| exit_req | output | 1 | Exit requested, with `done` |
| exit_code | output | 12 | Exit code, valid with `exit_req` |
| exit_info | output | 64 | Exit info, valid with `exit_req` |

## Verification
A check that needs no fetch is due exactly one clock after the edge that accepts it. A fetched check is due one clock after the edge that samples `mem_valid`. The memory responder in the bench sets the latency on purpose, including zero wait and several wait states. The driver places each expected outcome in a queue as it issues the request. The monitor samples on the falling edge and takes an item from the queue only when `done` is high. A missing, extra or early completion therefore shows up as a mismatch or as a leftover item. The ignored request made while busy is checked through the count of completions, and the fetched address is compared for every lookup.

// File: rtl/vm_intercept_unit.sv
module vm_intercept_unit #(
  parameter int TYPE_W = 12,
  parameter int INFO_W = 64,
  parameter int ADDR_W = 32,
  parameter logic [TYPE_W-1:0] CRR_BASE = 12'h000,
  parameter logic [TYPE_W-1:0] CRW_BASE = 12'h010,
  parameter logic [TYPE_W-1:0] DRR_BASE = 12'h020,
  parameter logic [TYPE_W-1:0] DRW_BASE = 12'h030,
  parameter logic [TYPE_W-1:0] EXC_BASE = 12'h040,
  parameter logic [TYPE_W-1:0] GEN_BASE = 12'h060,
  parameter logic [TYPE_W-1:0] MSR_CODE = 12'h07C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk_valid,
  input  logic [TYPE_W-1:0] chk_type,
  input  logic [INFO_W-1:0] chk_param,
  input  logic [31:0]       msr_index,
  input  logic              icpt_en,
  input  logic [63:0]       gen_vec,
  input  logic [15:0]       crr_map,
  input  logic [15:0]       crw_map,
  input  logic [15:0]       drr_map,
  input  logic [15:0]       drw_map,
  input  logic [31:0]       exc_map,
  input  logic [ADDR_W-1:0] map_base,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_valid,
  input  logic [7:0]        mem_data,
  output logic              busy,
  output logic              done,
  output logic              exit_req,
  output logic [TYPE_W-1:0] exit_code,
  output logic [INFO_W-1:0] exit_info
);
  localparam logic [TYPE_W-1:0] MSR_BIT = MSR_CODE - GEN_BASE;
  localparam logic [18:0] WIN_A = 19'h60000;
  localparam logic [18:0] WIN_B = 19'h60008;

  logic fetching, done_q, exit_q;
  logic [2:0] bit_q;
  logic [TYPE_W-1:0] code_q;
  logic [INFO_W-1:0] info_q;
  logic [ADDR_W-1:0] addr_q;

  wire accept = chk_valid && !fetching;

  wire [TYPE_W-1:0] d_crr = chk_type - CRR_BASE;
  wire [TYPE_W-1:0] d_crw = chk_type - CRW_BASE;
  wire [TYPE_W-1:0] d_drr = chk_type - DRR_BASE;
  wire [TYPE_W-1:0] d_drw = chk_type - DRW_BASE;
  wire [TYPE_W-1:0] d_exc = chk_type - EXC_BASE;
  wire [TYPE_W-1:0] d_gen = chk_type - GEN_BASE;

  wire in_crr = d_crr < TYPE_W'(9);
  wire in_crw = d_crw < TYPE_W'(9);
  wire in_drr = d_drr < TYPE_W'(8);
  wire in_drw = d_drw < TYPE_W'(8);
  wire in_exc = d_exc < TYPE_W'(32);
  wire in_gen = d_gen < TYPE_W'(64);
  wire is_msr = chk_type == MSR_CODE;
  wire msr_on = gen_vec[MSR_BIT[5:0]];

  wire win_lo = msr_index[31:13] == 19'd0;
  wire win_a  = msr_index[31:13] == WIN_A;
  wire win_b  = msr_index[31:13] == WIN_B;
  wire in_win = win_lo || win_a || win_b;
  wire [1:0] win_sel = {win_b, win_a};

  wire walk = icpt_en && is_msr && msr_on && in_win;
  wire [ADDR_W-1:0] walk_addr = map_base + ADDR_W'({win_sel, msr_index[12:2]});

  logic hit;
  always_comb begin
    hit = 1'b0;
    if (!icpt_en)    hit = 1'b0;
    else if (in_crr) hit = crr_map[d_crr[3:0]];
    else if (in_crw) hit = crw_map[d_crw[3:0]];
    else if (in_drr) hit = drr_map[d_drr[3:0]];
    else if (in_drw) hit = drw_map[d_drw[3:0]];
    else if (in_exc) hit = exc_map[d_exc[4:0]];
    else if (is_msr) hit = msr_on && !in_win;
    else if (in_gen) hit = gen_vec[d_gen[5:0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetching <= 1'b0;
      done_q   <= 1'b0;
      exit_q   <= 1'b0;
      bit_q    <= '0;
      code_q   <= '0;
      info_q   <= '0;
      addr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      exit_q <= 1'b0;
      if (fetching) begin
        if (mem_valid) begin
          fetching <= 1'b0;
          done_q   <= 1'b1;
          exit_q   <= mem_data[bit_q];
        end
      end else if (accept) begin
        code_q <= chk_type;
        info_q <= chk_param;
        if (walk) begin
          fetching <= 1'b1;
          addr_q   <= walk_addr;
          bit_q    <= {msr_index[1:0], chk_param[0]};
        end else begin
          done_q <= 1'b1;
          exit_q <= hit;
        end
      end
    end
  end

  assign mem_req   = fetching;
  assign mem_addr  = addr_q;
  assign busy      = fetching;
  assign done      = done_q;
  assign exit_req  = exit_q;
  assign exit_code = code_q;
  assign exit_info = info_q;

  AST_OFF_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !icpt_en) |=> (done && !exit_req && !mem_req)); // R1
  AST_OUT_WIN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && icpt_en && is_msr && msr_on && !in_win) |=> (done && exit_req && !mem_req)); // R9
  AST_EXIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> done); // R13
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R12
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_valid) |=> (done && !mem_req)); // R12
  AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_valid) |=> (busy && !done)); // R11
endmodule

// File: tb/vm_intercept_unit_tb_top.sv
module vm_intercept_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        chk_valid = 1'b0;
  logic [11:0] chk_type = '0;
  logic [63:0] chk_param = '0;
  logic [31:0] msr_index = '0;
  logic        icpt_en = 1'b0;
  logic [63:0] gen_vec = '0;
  logic [15:0] crr_map = '0, crw_map = '0, drr_map = '0, drw_map = '0;
  logic [31:0] exc_map = '0;
  logic [31:0] map_base = 32'h0001_0000;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data = '0;
  logic        busy, done, exit_req;
  logic [11:0] exit_code;
  logic [63:0] exit_info;

  vm_intercept_unit dut_i (
    .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_type(chk_type),
    .chk_param(chk_param), .msr_index(msr_index), .icpt_en(icpt_en),
    .gen_vec(gen_vec), .crr_map(crr_map), .crw_map(crw_map), .drr_map(drr_map),
    .drw_map(drw_map), .exc_map(exc_map), .map_base(map_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .busy(busy), .done(done), .exit_req(exit_req),
    .exit_code(exit_code), .exit_info(exit_info));

  typedef struct {
    string       tag;
    logic        ex;
    logic [11:0] code;
    logic [63:0] info;
    logic        fetch;
    logic [31:0] addr;
  } item_t;

  item_t sbq[$];
  int n_chk = 0, n_fail = 0;
  int lat_set = 0;
  logic        fetched = 1'b0;
  logic [31:0] fetch_addr = '0;

  function automatic logic [7:0] map_byte(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA6;
  endfunction

  function automatic item_t model(string tag, logic [11:0] t, logic [63:0] p, logic [31:0] m);
    item_t it;
    longint off;
    logic [7:0] b;
    it.tag = tag; it.code = t; it.info = p; it.ex = 1'b0; it.fetch = 1'b0; it.addr = '0;
    if (!icpt_en) return it;
    off = -1;
    if (t <= 8) it.ex = crr_map[t];
    else if (t >= 16 && t <= 24) it.ex = crw_map[t - 16];
    else if (t >= 32 && t <= 39) it.ex = drr_map[t - 32];
    else if (t >= 48 && t <= 55) it.ex = drw_map[t - 48];
    else if (t >= 64 && t <= 95) it.ex = exc_map[t - 64];
    else if (t == 12'h07C) begin
      if (gen_vec[28]) begin
        if (m <= 32'h1FFF) off = 2 * longint'(m);
        else if (m >= 32'hC000_0000 && m <= 32'hC000_1FFF) off = 2 * (8192 + longint'(m) - 64'hC000_0000);
        else if (m >= 32'hC001_0000 && m <= 32'hC001_1FFF) off = 2 * (16384 + longint'(m) - 64'hC001_0000);
        else it.ex = 1'b1;
        if (off >= 0) begin
          off = off + longint'(p[0]);
          it.fetch = 1'b1;
          it.addr = map_base + 32'(off / 8);
          b = map_byte(it.addr);
          it.ex = b[off % 8];
        end
      end
    end
    else if (t >= 96 && t <= 159) it.ex = gen_vec[t - 96];
    return it;
  endfunction

  task automatic drive(logic [11:0] t, logic [63:0] p, logic [31:0] m);
    @(negedge clk);
    chk_valid = 1'b1; chk_type = t; chk_param = p; msr_index = m;
    @(negedge clk);
    chk_valid = 1'b0;
  endtask

  task automatic run(string tag, logic [11:0] t, logic [63:0] p, logic [31:0] m);
    sbq.push_back(model(tag, t, p, m));
    drive(t, p, m);
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // memory responder
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_valid) mem_valid = 1'b0;
      else if (mem_req) begin
        if (cnt >= lat_set) begin
          mem_valid = 1'b1;
          mem_data = map_byte(mem_addr);
          fetched = 1'b1;
          fetch_addr = mem_addr;
          cnt = 0;
        end else cnt++;
      end
    end
  end

  // monitor
  initial begin
    item_t e;
    forever begin
      @(negedge clk);
      if (rst_n && exit_req && !done) begin
        n_chk++; n_fail++;
        $display("FAIL R13: exit_req=1 with done=0 (expected done=1)");
      end
      if (rst_n && done) begin
        n_chk++;
        if (sbq.size() == 0) begin
          n_fail++;
          $display("FAIL R11: unexpected done, exit=%0b code=%h (expected no completion)", exit_req, exit_code);
        end else begin
          e = sbq.pop_front();
          if (exit_req !== e.ex || (e.ex && (exit_code !== e.code || exit_info !== e.info))
              || fetched !== e.fetch || (e.fetch && fetch_addr !== e.addr)) begin
            n_fail++;
            $display("FAIL %s: exit=%0b code=%h info=%h fetch=%0b addr=%h expected exit=%0b code=%h info=%h fetch=%0b addr=%h",
                     e.tag, exit_req, exit_code, exit_info, fetched, fetch_addr,
                     e.ex, e.code, e.info, e.fetch, e.addr);
          end
        end
        fetched = 1'b0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish (expected completion)");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (done !== 1'b0 || exit_req !== 1'b0 || mem_req !== 1'b0 || busy !== 1'b0) begin
      n_fail++;
      $display("FAIL R13: reset outputs done=%b exit=%b req=%b busy=%b expected 0 0 0 0",
               done, exit_req, mem_req, busy);
    end

    crr_map = '1; crw_map = '1; drr_map = '1; drw_map = '1; exc_map = '1; gen_vec = '1;
    icpt_en = 1'b0;
    run("R1", 12'h003, 64'd0, 32'd0);
    run("R1", 12'h07C, 64'd1, 32'h0000_0010);
    run("R1", 12'h060, 64'd0, 32'd0);

    icpt_en = 1'b1;
    crr_map = 16'h0108; crw_map = 16'h0100; drr_map = 16'h0080; drw_map = 16'h0002;
    exc_map = 32'h8000_0000; gen_vec = 64'h8000_0000_1000_0001;
    run("R2", 12'h003, 64'h11, 32'd0);
    run("R2", 12'h005, 64'h12, 32'd0);
    run("R2", 12'h008, 64'h13, 32'd0);
    run("R2", 12'h018, 64'h14, 32'd0);
    run("R2", 12'h010, 64'h15, 32'd0);
    run("R3", 12'h027, 64'h21, 32'd0);
    run("R3", 12'h020, 64'h22, 32'd0);
    run("R3", 12'h031, 64'h23, 32'd0);
    run("R4", 12'h05F, 64'h31, 32'd0);
    run("R4", 12'h04E, 64'h32, 32'd0);
    run("R5", 12'h060, 64'h41, 32'd0);
    run("R5", 12'h09F, 64'h42, 32'd0);
    run("R5", 12'h061, 64'h43, 32'd0);
    run("R5", 12'h0A0, 64'h44, 32'd0);
    run("R5", 12'h00C, 64'h45, 32'd0);

    gen_vec[28] = 1'b0;
    run("R6", 12'h07C, 64'd0, 32'h0000_0010);
    run("R6", 12'h07C, 64'd0, 32'hFFFF_FFFF);
    gen_vec[28] = 1'b1;

    lat_set = 0;
    run("R7", 12'h07C, 64'd0, 32'h0000_0010);
    run("R8", 12'h07C, 64'd1, 32'h0000_0010);
    lat_set = 2;
    run("R7", 12'h07C, 64'd0, 32'h0000_1FFF);
    run("R8", 12'h07C, 64'd1, 32'h0000_1FFF);
    lat_set = 1;
    run("R7", 12'h07C, 64'd0, 32'hC000_0080);
    run("R8", 12'h07C, 64'd1, 32'hC000_1FFF);
    lat_set = 3;
    run("R7", 12'h07C, 64'd0, 32'hC001_0015);
    run("R8", 12'h07C, 64'd1, 32'hC001_1FFE);
    run("R7", 12'h07C, 64'd0, 32'hC001_1FFF);

    run("R9", 12'h07C, 64'd0, 32'h0000_2000);
    run("R9", 12'h07C, 64'd1, 32'hC000_2000);
    run("R9", 12'h07C, 64'd0, 32'hFFFF_FFFF);

    run("R10", 12'h09F, 64'hDEAD_BEEF_0123_4567, 32'd0);

    // R11: a request while busy is ignored
    lat_set = 5;
    sbq.push_back(model("R11", 12'h07C, 64'd0, 32'hC000_0040));
    drive(12'h07C, 64'd0, 32'hC000_0040);
    chk_valid = 1'b1; chk_type = 12'h060; chk_param = 64'h99;
    repeat (2) @(negedge clk);
    chk_valid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    // R13: back-to-back plain checks, each with its own completion
    sbq.push_back(model("R13", 12'h003, 64'h51, 32'd0));
    sbq.push_back(model("R13", 12'h005, 64'h52, 32'd0));
    @(negedge clk);
    chk_valid = 1'b1; chk_type = 12'h003; chk_param = 64'h51;
    @(negedge clk);
    chk_type = 12'h005; chk_param = 64'h52;
    @(negedge clk);
    chk_valid = 1'b0;
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);

    n_chk++;
    if (sbq.size() != 0) begin
      n_fail++;
      $display("FAIL R13: %0d completions missing (expected 0)", sbq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule